// File: doc/BRIEF.md
# Three-Stage Elastic Word Pipeline

This block pushes a stream of words through three fixed transforms: an addition of a constant, then an XOR with a mask, then a left rotation. Each transform sits between two one-entry queues rather than between plain pipeline registers. An entry queue takes words from a ready/valid source, and an exit queue offers results to a ready/valid sink. No central controller exists. A stage moves a word when the queue in front of it holds one and the queue behind it can take one. A stall at the sink therefore ripples back only as far as the queues that are actually full.

Each queue is a two-state machine with the states EMPTY and HELD. The transitions are named TAKE (EMPTY to HELD on a write), DRAIN (HELD to EMPTY on a read with no write), SWAP (HELD to HELD, reading and writing in the same cycle) and HOLD (HELD to HELD, with no read). The queue acts as if the head is looked at first, then removed, then refilled. A full queue that is being read can therefore accept a new word in the same cycle, so a fully flowing pipe moves one word per clock. A word accepted at a clock edge appears at the exit three edges later.

Top module: `epipe_top`

## Requirements
- R1: A synchronous active-high reset empties every queue. In the first cycle after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The words leaving the block match the accepted input words, in the same order, each transformed to rotl((x + ADD_K) ^ XOR_M, ROT_N mod W).
- R3: A HELD queue whose reader takes its word in a cycle also accepts a word offered in that cycle (SWAP). It holds a word again in the next cycle.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged in the next cycle (HOLD).
- R5: When `in_valid` and `out_ready` are held at 1, the block delivers one word on every cycle once the pipe has filled.
- R6: When no input is offered, words already inside keep moving toward the exit and leave on consecutive cycles if `out_ready` is 1.
- R7: A word moves across a boundary exactly on cycles when that boundary's valid and ready are both 1. Every accepted word leaves exactly once.
- R8: With `out_ready` held at 0, the block accepts exactly four words from an empty state and then holds `in_ready` at 0.
- R9: `in_ready` and `out_valid` follow, on every cycle, the occupancy implied by the handshakes seen so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source offers a word |
| in_ready | output | 1 | Entry queue can take a word |
| in_data | input | W | Word offered by the source |
| out_valid | output | 1 | Exit queue holds a result |
| out_ready | input | 1 | Sink takes the result |
| out_data | output | W | Result word |

## Verification
The first pattern drives random `in_valid` and random `out_ready`. It mixes TAKE, DRAIN, SWAP and HOLD in every queue, and a per-cycle model exposes any wrong ready or valid. The second pattern holds both handshakes high, which separates a queue that refills while it is being read from one that leaves a bubble. The third pattern stops the sink, which tests the fill limit of four words and the stable held result. The fourth pattern then stops the source, which shows whether the inner stages still drain by themselves.

// File: rtl/epipe_pkg.sv
package epipe_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;

    typedef enum logic [1:0] {
        XF_ADD  = 2'd0,
        XF_XOR  = 2'd1,
        XF_ROTL = 2'd2
    } xform_e;

    function automatic xform_e stage_kind(input int idx);
        case (idx)
            0:       return XF_ADD;
            1:       return XF_XOR;
            default: return XF_ROTL;
        endcase
    endfunction

endpackage

// File: rtl/epipe_slot.sv
module epipe_slot
    import epipe_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    slot_state_e state_q, state_d;
    logic [W-1:0] data_q;
    logic         load;

    // next-state: TAKE, DRAIN, SWAP, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (in_valid) state_d = SLOT_HELD;       // TAKE
            end
            SLOT_HELD: begin
                if (out_ready && !in_valid) state_d = SLOT_EMPTY; // DRAIN
                else state_d = SLOT_HELD;                // SWAP or HOLD
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SLOT_EMPTY;
        else     state_q <= state_d;
    end

    // outputs: head read, then dequeue, then enqueue
    always_comb begin
        out_valid = 1'b0;
        in_ready  = 1'b1;
        unique case (state_q)
            SLOT_EMPTY: begin
                out_valid = 1'b0;
                in_ready  = 1'b1;
            end
            SLOT_HELD: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
            end
        endcase
    end

    assign load     = in_valid && in_ready;
    assign out_data = data_q;

    always_ff @(posedge clk) begin
        if (load) data_q <= in_data;
    end

    AST_RESET_EMPTY: assert property (@(posedge clk) $past(rst) |-> !out_valid); // R1
    AST_SWAP_KEEPS:  assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && in_valid) |=> out_valid); // R3
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R4
    AST_TAKE_VALID:  assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid); // R7

endmodule

// File: rtl/epipe_stage.sv
module epipe_stage
    import epipe_pkg::*;
#(
    parameter int     W    = 32,
    parameter xform_e KIND = XF_ADD,
    parameter logic [W-1:0] ARG = '0
) (
    input  logic         src_valid,
    output logic         src_ready,
    input  logic [W-1:0] src_data,
    output logic         dst_valid,
    input  logic         dst_ready,
    output logic [W-1:0] dst_data
);

    localparam int SH = int'(ARG % W);

    // a transfer dequeues and enqueues together
    assign dst_valid = src_valid;
    assign src_ready = dst_ready;

    generate
        if (KIND == XF_ADD) begin : g_add
            assign dst_data = src_data + ARG;
        end else if (KIND == XF_XOR) begin : g_xor
            assign dst_data = src_data ^ ARG;
        end else begin : g_rotl
            if (SH == 0) begin : g_none
                assign dst_data = src_data;
            end else begin : g_shift
                assign dst_data = (src_data << SH) | (src_data >> (W - SH));
            end
        end
    endgenerate

endmodule

// File: rtl/epipe_top.sv
module epipe_top
    import epipe_pkg::*;
#(
    parameter int W = 32,
    parameter logic [W-1:0] ADD_K = 32'h0000_1357,
    parameter logic [W-1:0] XOR_M = 32'hA5A5_0F0F,
    parameter logic [W-1:0] ROT_N = 32'd7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    localparam int NSTAGE = 3;
    localparam int NSLOT  = NSTAGE + 1;

    logic         s_wv [NSLOT];
    logic         s_wr [NSLOT];
    logic [W-1:0] s_wd [NSLOT];
    logic         s_rv [NSLOT];
    logic         s_rr [NSLOT];
    logic [W-1:0] s_rd [NSLOT];

    assign s_wv[0]  = in_valid;
    assign in_ready = s_wr[0];
    assign s_wd[0]  = in_data;

    assign out_valid         = s_rv[NSLOT-1];
    assign s_rr[NSLOT-1]     = out_ready;
    assign out_data          = s_rd[NSLOT-1];

    generate
        for (genvar k = 0; k < NSLOT; k++) begin : g_slot
            epipe_slot #(.W(W)) u_slot (
                .clk      (clk),
                .rst      (rst),
                .in_valid (s_wv[k]),
                .in_ready (s_wr[k]),
                .in_data  (s_wd[k]),
                .out_valid(s_rv[k]),
                .out_ready(s_rr[k]),
                .out_data (s_rd[k])
            );
        end
        for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
            localparam xform_e KIND = stage_kind(k);
            localparam logic [W-1:0] ARG = (k == 0) ? ADD_K : (k == 1) ? XOR_M : ROT_N;
            epipe_stage #(.W(W), .KIND(KIND), .ARG(ARG)) u_stage (
                .src_valid(s_rv[k]),
                .src_ready(s_rr[k]),
                .src_data (s_rd[k]),
                .dst_valid(s_wv[k+1]),
                .dst_ready(s_wr[k+1]),
                .dst_data (s_wd[k+1])
            );
        end
    endgenerate

    AST_EXIT_DRAINS: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && out_ready && !s_rv[NSLOT-2] && !s_rv[NSLOT-3] && !s_rv[0]) |=> !out_valid); // R6
    AST_ENTRY_REFILL: assert property (@(posedge clk) disable iff (rst)
        (out_ready && s_rv[0] && s_rv[1] && s_rv[2] && out_valid) |-> in_ready); // R3

endmodule

// File: tb/epipe_top_test.sv
`timescale 1ns/1ps
module epipe_top_test;

    localparam int W = 32;
    localparam logic [31:0] K = 32'h0000_1357;
    localparam logic [31:0] M = 32'hA5A5_0F0F;
    localparam int RN = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [W-1:0] in_data = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [W-1:0] out_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    epipe_top uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    // behavioural model: four one-word queues
    bit          occ [4];
    logic [31:0] dat [4];
    logic [31:0] expq [$];
    int accepted = 0;
    int delivered = 0;
    bit prev_stall = 1'b0;
    logic [31:0] prev_data = '0;

    function automatic logic [31:0] rotl(input logic [31:0] x);
        return (x << RN) | (x >> (32 - RN));
    endfunction

    function automatic logic [31:0] apply(input int idx, input logic [31:0] x);
        if (idx == 0) return x + K;
        if (idx == 1) return x ^ M;
        return rotl(x);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input bit v, input logic [31:0] d, input bit r);
        bit rdy [4];
        bit mv [4];
        bit tk [4];
        bit nocc [4];
        logic [31:0] ndat [4];
        @(negedge clk);
        in_valid = v; in_data = d; out_ready = r;
        #1;
        rdy[3] = !occ[3] || r;
        for (int k = 2; k >= 0; k--) rdy[k] = !occ[k] || rdy[k+1];
        // R9 per-cycle handshake view
        check(in_ready == rdy[0], "R9 in_ready", {31'b0, in_ready}, {31'b0, rdy[0]});
        check(out_valid == occ[3], "R9 out_valid", {31'b0, out_valid}, {31'b0, occ[3]});
        if (occ[3]) check(out_data == dat[3], "R7 out_data", out_data, dat[3]);
        if (prev_stall) begin
            check(out_valid && out_data == prev_data, "R4 held output", out_data, prev_data);
        end
        prev_stall = out_valid && !r;
        prev_data = out_data;
        if (out_valid && r) begin
            logic [31:0] e;
            e = (expq.size() > 0) ? expq.pop_front() : 32'hDEAD_BEEF;
            check(out_data == e, "R2 sequence", out_data, e);
            delivered++;
        end
        if (v && in_ready) begin
            expq.push_back(rotl((d + K) ^ M));
            accepted++;
        end
        for (int k = 0; k < 4; k++) begin
            mv[k] = occ[k] && ((k == 3) ? r : rdy[k+1]);
            tk[k] = (k == 0) ? (v && rdy[0]) : mv[k-1];
        end
        for (int k = 0; k < 4; k++) begin
            nocc[k] = occ[k]; ndat[k] = dat[k];
            if (tk[k]) begin
                nocc[k] = 1'b1;
                ndat[k] = (k == 0) ? d : apply(k - 1, dat[k-1]);
            end else if (mv[k]) nocc[k] = 1'b0;
        end
        @(posedge clk);
        for (int k = 0; k < 4; k++) begin occ[k] = nocc[k]; dat[k] = ndat[k]; end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int cnt;
        int acc0;
        for (int k = 0; k < 4; k++) begin occ[k] = 1'b0; dat[k] = '0; end
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check(out_valid == 1'b0, "R1 reset out_valid", {31'b0, out_valid}, 32'd0);
        check(in_ready == 1'b1, "R1 reset in_ready", {31'b0, in_ready}, 32'd1);
        @(posedge clk);

        // random valid and ready: TAKE, DRAIN, SWAP, HOLD mixed (R3, R7)
        for (int i = 0; i < 3000; i++)
            step(($urandom % 3) != 0, $urandom, ($urandom % 4) != 0);
        step(1'b0, '0, 1'b1); step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b1); step(1'b0, '0, 1'b1); step(1'b0, '0, 1'b1);

        // R5 full throughput
        for (int i = 0; i < 10; i++) step(1'b1, $urandom, 1'b1);
        cnt = delivered;
        for (int i = 0; i < 100; i++) step(1'b1, $urandom, 1'b1);
        check(delivered - cnt == 100, "R5 throughput", delivered - cnt, 32'd100);
        for (int i = 0; i < 6; i++) step(1'b0, '0, 1'b1);
        check(expq.size() == 0, "R7 all delivered", expq.size(), 32'd0);

        // R8 fill limit with sink stopped
        acc0 = accepted;
        for (int i = 0; i < 10; i++) step(1'b1, 32'h1000 + i, 1'b0);
        check(accepted - acc0 == 4, "R8 fill count", accepted - acc0, 32'd4);
        #1;
        check(in_ready == 1'b0, "R8 in_ready low", {31'b0, in_ready}, 32'd0);

        // R6 drain with source idle
        cnt = delivered;
        for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1);
        check(delivered - cnt == 4, "R6 drain count", delivered - cnt, 32'd4);
        check(expq.size() == 0, "R2 scoreboard empty", expq.size(), 32'd0);
        step(1'b0, '0, 1'b1);

        // R3 swap on a full pipe, then random again
        for (int i = 0; i < 4; i++) step(1'b1, $urandom, 1'b0);
        for (int i = 0; i < 8; i++) step(1'b1, $urandom, 1'b1);
        for (int i = 0; i < 1000; i++)
            step(($urandom % 2) != 0, $urandom, ($urandom % 2) != 0);
        for (int i = 0; i < 8; i++) step(1'b0, '0, 1'b1);
        check(expq.size() == 0, "R7 final drain", expq.size(), 32'd0);
        check(accepted == delivered, "R7 count match", delivered, accepted);
        finish_run();
    end

endmodule